// File: doc/BRIEF.md
# Clocked Slave Serial Transmitter

This block is the transmit half of a synchronous serial port that runs as a slave: an external master owns the shift clock and the block only answers it. A host writes 8-bit words, each optionally widened by a ninth bit, through a one-cycle write strobe. A word written while the shifter is idle goes straight into the shift register. A word written while a transfer is in progress waits in a single holding slot. The block puts the word on its data pin least significant bit first, one bit per external clock period.

The external clock passes through a synchroniser into the system clock domain. The line advances on the falling edge of the synchronised clock, so each bit is steady when the master samples on its rising edge. When the final bit of a word has been clocked out, a held word moves into the shifter on that same falling edge, so two queued words go out with no host action between them. Two flags report the buffer state: one for the holding slot and one for the shifter. An interrupt request follows the holding-slot flag when its enable is set.

The shifter is a three-state machine. **IDLE** has no word loaded and the line is high. **SHIFT** has a word loaded with two or more bits still to send. **LAST** has only the final bit on the line. The transitions are: *start* (IDLE to SHIFT on a load), *step* (SHIFT to SHIFT on a falling edge that leaves more than one bit), *tail* (SHIFT to LAST on the falling edge that leaves one bit), *chain* (LAST to SHIFT on the final falling edge when a word is held), *drain* (LAST to IDLE on the final falling edge when nothing is held), and *abort* (any state to IDLE when the transmitter is not active).

Top module: `sync_slave_tx`

## Requirements
- R1: The transmitter is active only when port_en=1, sync_mode=1, clk_src_master=0, rx_cont_en=0, rx_single_en=0 and tx_en=1. While inactive, data_oe=0, writes are ignored, and one clock after becoming inactive both hold_empty and shift_empty read 1 (any word in progress or held is discarded).
- R2: After reset, hold_empty=1, shift_empty=1, data_out=1 and irq=0 with irq_en=0.
- R3: A write accepted while shift_empty=1 loads the shifter directly. In the following cycle shift_empty=0, hold_empty stays 1, and data_out shows bit 0 of the word.
- R4: Bits leave least significant first. Each falling edge of ext_sck advances the line by one bit, and 8 bits are sent when nine_bit_mode=0.
- R5: When nine_bit_mode=1 at the write, the value of ninth_bit at that write is captured and sent as a ninth bit after bit 7.
- R6: A write accepted while a word is shifting is stored in the holding slot, and hold_empty reads 0 until that word moves on.
- R7: On the falling edge that ends a word, a held word enters the shifter and hold_empty returns to 1 in the same cycle. Its bit 0 is on the line for the next rising edge of ext_sck.
- R8: A write made while hold_empty=0 is dropped, and the held word is sent unchanged.
- R9: irq is 1 exactly when hold_empty=1 and irq_en=1.
- R10: After the last bit of a word with nothing held, shift_empty returns to 1 and data_out rests at 1.
- R11: ext_sck passes through a two-flop synchroniser and one edge-detect flop. data_out changes on the third system clock edge after the falling ext_sck level is first sampled, and never while ext_sck stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Selects synchronous operation |
| clk_src_master | input | 1 | Clock-source select; must be 0 for slave operation |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 to transmit |
| rx_single_en | input | 1 | Single receive enable; must be 0 to transmit |
| tx_en | input | 1 | Transmitter enable |
| nine_bit_mode | input | 1 | Adds a ninth bit to words written while set |
| ninth_bit | input | 1 | Ninth bit value captured with the word |
| wr_valid | input | 1 | One-cycle write strobe for wr_data |
| wr_data | input | 8 | Data word |
| irq_en | input | 1 | Interrupt enable for the holding-slot flag |
| ext_sck | input | 1 | Shift clock from the external master |
| data_out | output | 1 | Serial data line |
| data_oe | output | 1 | Data line drive enable |
| hold_empty | output | 1 | Holding slot is free |
| shift_empty | output | 1 | No word is shifting |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several properties. Deactivation flushes both flags within one cycle. A held word never sits beside an idle shifter. A direct load leaves the holding flag high. The idle line stays high. The interrupt needs its enable. Any change of the line during a transfer must follow the exact synchroniser delay after a falling clock. Only the bench scenarios show the serial bit order, the capture of the ninth bit at write time, the gapless handoff of a queued word, and the loss of a third write made while the slot is full.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_LAST  = 2'd2
    } tx_state_e;

    function automatic int unsigned frame_bits(input int unsigned data_w, input logic nine);
        return nine ? data_w + 1 : data_w;
    endfunction
endpackage

// File: rtl/sstx_clk_sync.sv
module sstx_clk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_async,
    output logic sck_fall
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= sck_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // falling edge of the synchronised clock: older stage high, newer low
    assign sck_fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];
endmodule

// File: rtl/sstx_hold.sv
module sstx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nine_bit_mode,
    input  logic              ninth_bit,
    input  logic              sh_idle,
    input  logic              sh_finish,
    output logic              load,
    output logic [DATA_W:0]   load_word,
    output logic              load_nine,
    output logic              hold_empty
);
    localparam int unsigned SLOT_W = DATA_W + 2;

    logic [SLOT_W-1:0] slot_q;
    logic              full_q;
    logic [SLOT_W-1:0] word_in;
    logic              accept;
    logic              direct;
    logic              from_slot;

    always_comb begin
        word_in   = {nine_bit_mode, nine_bit_mode & ninth_bit, wr_data};
        accept    = active & wr_valid & ~full_q;
        direct    = accept & (sh_idle | sh_finish);
        from_slot = active & full_q & sh_finish;
        load      = direct | from_slot;
        load_word = from_slot ? slot_q[DATA_W:0] : word_in[DATA_W:0];
        load_nine = from_slot ? slot_q[SLOT_W-1] : word_in[SLOT_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            slot_q <= '0;
        end else if (!active) begin
            full_q <= 1'b0;
        end else if (from_slot) begin
            full_q <= 1'b0;
        end else if (accept && !direct) begin
            full_q <= 1'b1;
            slot_q <= word_in;
        end
    end

    assign hold_empty = ~full_q;
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
    import sstx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            sck_fall,
    input  logic            load,
    input  logic [DATA_W:0] load_word,
    input  logic            load_nine,
    output logic            idle,
    output logic            finish,
    output logic            line
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 2);

    tx_state_e          state_q, state_d;
    logic [DATA_W:0]    sr_q;
    logic [CNT_W-1:0]   left_q;

    // next state
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = TX_IDLE;                       // abort
        end else begin
            unique case (state_q)
                TX_IDLE:  if (load) state_d = TX_SHIFT;  // start
                TX_SHIFT: if (sck_fall) state_d = (left_q == CNT_W'(2)) ? TX_LAST : TX_SHIFT; // tail / step
                TX_LAST:  if (sck_fall) state_d = load ? TX_SHIFT : TX_IDLE;  // chain / drain
                default:  state_d = TX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (!active) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sr_q   <= load_word;
            left_q <= CNT_W'(frame_bits(DATA_W, load_nine));
        end else if (sck_fall && state_q != TX_IDLE) begin
            sr_q   <= sr_q >> 1;
            left_q <= left_q - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        idle   = (state_q == TX_IDLE);
        finish = (state_q == TX_LAST) & sck_fall;
        line   = (state_q == TX_IDLE) ? 1'b1 : sr_q[0];
    end
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_src_master,
    input  logic              rx_cont_en,
    input  logic              rx_single_en,
    input  logic              tx_en,
    input  logic              nine_bit_mode,
    input  logic              ninth_bit,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    input  logic              ext_sck,
    output logic              data_out,
    output logic              data_oe,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              irq
);
    logic            active;
    logic            sck_fall;
    logic            sh_idle;
    logic            sh_finish;
    logic            load;
    logic [DATA_W:0] load_word;
    logic            load_nine;

    assign active = port_en & sync_mode & ~clk_src_master
                  & ~rx_cont_en & ~rx_single_en & tx_en;

    sstx_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_async (ext_sck),
        .sck_fall  (sck_fall)
    );

    sstx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .nine_bit_mode (nine_bit_mode),
        .ninth_bit     (ninth_bit),
        .sh_idle       (sh_idle),
        .sh_finish     (sh_finish),
        .load          (load),
        .load_word     (load_word),
        .load_nine     (load_nine),
        .hold_empty    (hold_empty)
    );

    sstx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .sck_fall  (sck_fall),
        .load      (load),
        .load_word (load_word),
        .load_nine (load_nine),
        .idle      (sh_idle),
        .finish    (sh_finish),
        .line      (data_out)
    );

    assign shift_empty = sh_idle;
    assign data_oe     = active;
    assign irq         = hold_empty & irq_en;
endmodule

// File: rtl/sstx_checker.sv
module sstx_checker (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic sync_mode,
    input logic clk_src_master,
    input logic rx_cont_en,
    input logic rx_single_en,
    input logic tx_en,
    input logic wr_valid,
    input logic irq_en,
    input logic ext_sck,
    input logic data_out,
    input logic hold_empty,
    input logic shift_empty,
    input logic irq
);
    logic run;
    assign run = port_en & sync_mode & ~clk_src_master & ~rx_cont_en & ~rx_single_en & tx_en;

    AST_OFF_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hold_empty && shift_empty)); // R1

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_valid && shift_empty && hold_empty) |=> (!shift_empty && hold_empty)); // R3

    AST_HELD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_empty |-> !shift_empty); // R6

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> data_out); // R10

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && hold_empty)); // R9

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_empty && $past(!shift_empty) && (data_out != $past(data_out)))
        |-> (!$past(ext_sck, 3) && $past(ext_sck, 4))); // R11
endmodule

bind sync_slave_tx sstx_checker u_sstx_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .port_en        (port_en),
    .sync_mode      (sync_mode),
    .clk_src_master (clk_src_master),
    .rx_cont_en     (rx_cont_en),
    .rx_single_en   (rx_single_en),
    .tx_en          (tx_en),
    .wr_valid       (wr_valid),
    .irq_en         (irq_en),
    .ext_sck        (ext_sck),
    .data_out       (data_out),
    .hold_empty     (hold_empty),
    .shift_empty    (shift_empty),
    .irq            (irq)
);

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b0, sync_mode = 1'b0, clk_src_master = 1'b0;
    logic rx_cont_en = 1'b0, rx_single_en = 1'b0, tx_en = 1'b0;
    logic nine_bit_mode = 1'b0, ninth_bit = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic irq_en = 1'b0, ext_sck = 1'b0;
    logic data_out, data_oe, hold_empty, shift_empty, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sync_slave_tx i_sync_slave_tx (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .clk_src_master(clk_src_master), .rx_cont_en(rx_cont_en),
        .rx_single_en(rx_single_en), .tx_en(tx_en), .nine_bit_mode(nine_bit_mode),
        .ninth_bit(ninth_bit), .wr_valid(wr_valid), .wr_data(wr_data),
        .irq_en(irq_en), .ext_sck(ext_sck), .data_out(data_out), .data_oe(data_oe),
        .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
    );

    // vector: {nine_mode, ninth, data}
    localparam logic [9:0] VECS [6] = '{
        10'b0_0_10100101, 10'b0_0_00000001, 10'b1_1_01100011,
        10'b1_0_11111111, 10'b0_1_10000000, 10'b1_1_00000000
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [7:0] d, input logic nm, input logic nb);
        @(negedge clk);
        wr_data = d; nine_bit_mode = nm; ninth_bit = nb; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic sck_bit(output logic seen);
        @(negedge clk);
        ext_sck = 1'b1;
        repeat (4) @(negedge clk);
        seen = data_out;
        ext_sck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_check(input string tag, input logic [7:0] d, input logic nm, input logic nb);
        logic b;
        for (int i = 0; i < 8; i++) begin
            sck_bit(b);
            check(tag, b, d[i]);
        end
        if (nm) begin
            sck_bit(b);
            check({tag, " ninth"}, b, nb);
        end
    endtask

    task automatic activate();
        @(negedge clk);
        port_en = 1'b1; sync_mode = 1'b1; clk_src_master = 1'b0;
        rx_cont_en = 1'b0; rx_single_en = 1'b0; tx_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic b;
        repeat (4) @(negedge clk);
        // R2 reset state
        check("R2 hold_empty", hold_empty, 1);
        check("R2 shift_empty", shift_empty, 1);
        check("R2 data_out", data_out, 1);
        check("R2 irq", irq, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 oe off", data_oe, 0);
        activate();
        @(negedge clk);
        check("R1 oe on", data_oe, 1);

        // table walk: R3 R4 R5 R10
        for (int v = 0; v < 6; v++) begin
            write_word(VECS[v][7:0], VECS[v][9], VECS[v][8]);
            check("R3 shift busy", shift_empty, 0);
            check("R3 hold still empty", hold_empty, 1);
            check("R3 bit0 on line", data_out, VECS[v][0]);
            send_check(VECS[v][9] ? "R5 frame" : "R4 frame", VECS[v][7:0], VECS[v][9], VECS[v][8]);
            check("R10 idle again", shift_empty, 1);
            check("R10 line high", data_out, 1);
        end

        // R11 synchroniser latency: word 0x02, bit0=0 bit1=1
        write_word(8'h02, 1'b0, 1'b0);
        @(negedge clk); ext_sck = 1'b1;
        repeat (4) @(negedge clk);
        ext_sck = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 not yet", data_out, 0);
        @(negedge clk);
        check("R11 third edge", data_out, 1);
        repeat (4) @(negedge clk);
        for (int i = 1; i < 8; i++) sck_bit(b);
        check("R11 drained", shift_empty, 1);

        // R6 R7 R8 R9 queueing
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 irq when empty", irq, 1);
        write_word(8'h3C, 1'b0, 1'b0);
        write_word(8'hA9, 1'b0, 1'b0);
        check("R6 held", hold_empty, 0);
        check("R9 irq low when full", irq, 0);
        write_word(8'hFF, 1'b0, 1'b0);           // R8 dropped
        for (int i = 0; i < 7; i++) begin
            sck_bit(b);
            check("R4 first word", b, (8'h3C >> i) & 1);
        end
        check("R7 still held", hold_empty, 0);
        sck_bit(b);
        check("R4 first word last", b, 0);
        check("R7 hold freed", hold_empty, 1);
        check("R7 chained busy", shift_empty, 0);
        check("R9 irq back", irq, 1);
        send_check("R8 held word intact", 8'hA9, 1'b0, 1'b0);
        check("R10 after chain", shift_empty, 1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R9 irq disabled", irq, 0);

        // R1 inactive combinations ignore writes
        @(negedge clk); tx_en = 1'b0;
        write_word(8'h55, 1'b0, 1'b0);
        check("R1 tx off ignores", shift_empty, 1);
        check("R1 tx off oe", data_oe, 0);
        activate(); rx_cont_en = 1'b1;
        write_word(8'h55, 1'b0, 1'b0);
        check("R1 rx cont ignores", shift_empty, 1);
        activate(); rx_single_en = 1'b1;
        write_word(8'h55, 1'b0, 1'b0);
        check("R1 rx single ignores", shift_empty, 1);
        activate(); clk_src_master = 1'b1;
        write_word(8'h55, 1'b0, 1'b0);
        check("R1 master sel ignores", shift_empty, 1);
        activate(); sync_mode = 1'b0;
        write_word(8'h55, 1'b0, 1'b0);
        check("R1 async ignores", shift_empty, 1);

        // R1 flush of a word in progress and a held word
        activate();
        write_word(8'h81, 1'b0, 1'b0);
        write_word(8'h42, 1'b0, 1'b0);
        check("R1 pre-flush held", hold_empty, 0);
        @(negedge clk); port_en = 1'b0;
        @(negedge clk);
        check("R1 flush hold", hold_empty, 1);
        check("R1 flush shift", shift_empty, 1);
        activate();
        @(negedge clk);
        check("R1 stays idle", shift_empty, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule